// File: doc/BRIEF.md
# Watch Timekeeping Core

This block keeps time of day for a low-power digital watch that runs from a 32,768 Hz crystal clock. A binary counter divides that clock down to one pulse per second. Cascaded decimal digit counters count seconds, minutes and hours, and the hours run on a twelve-hour dial. A second, faster pulse taken from the low end of the same counter scans the four display digits. Each digit shows the tens or units of the hours or of the minutes.

A single seven-segment decoder serves all four digits. A digit pointer selects the value the decoder sees and enables the matching digit drive. The display stays completely dark unless the wearer holds the show request. While the set input is held, the upper divider stages are skipped, so the seconds count runs fast until the input is released. Nothing is loaded directly into the digits.

Top module: `watch_core`

## Requirements
- R1: A low `rst_n` sampled at a clock edge clears the divider and the digit pointer to zero and sets the time to 12:00:00.
- R2: With `fast_set` low, the seconds count advances once every 2^DIV_STAGES clocks. With the defaults this is once per second from 32,768 Hz.
- R3: Seconds and minutes each run units 0..9 and tens 0..5. A units wrap carries into the tens, and the minutes advance only when the seconds go from 59 to 00.
- R4: Hours follow 12, 1, 2, ..., 11, 12, advancing when minutes and seconds go from 59:59 to 00:00.
- R5: While `fast_set` is high, the seconds count advances once every 2^(DIV_STAGES-FAST_SKIP) clocks. With the defaults this is 256 Hz.
- R6: The digit pointer advances every 2^SCAN_BITS clocks and cycles 0, 1, 2, 3, 0. Slot 0 is minutes units, slot 1 is minutes tens, slot 2 is hours units and slot 3 is hours tens. `dig_en[i]` drives slot i.
- R7: `seg_out` is active high, with bit 6..0 = g f e d c b a. The digits 0..9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). Codes above 9 give 00.
- R8: When `show_req` is low, `seg_out` and `dig_en` are all zero. Timekeeping continues unaffected.
- R9: When the hours tens digit is 0 and slot 3 is selected, both `seg_out` and `dig_en` are zero.
- R10: At most one bit of `dig_en` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, nominally 32,768 Hz |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_set | input | 1 | Hold high to run the time fast |
| show_req | input | 1 | Hold high to light the display |
| seg_out | output | 7 | Segment drives, active high, g..a |
| dig_en | output | 4 | One-hot digit drive, slot 0 = minutes units |

## Verification
The bench runs a small divider configuration so that a fast-set sweep can cover a full twelve-hour cycle. A cycle-accurate arithmetic model predicts the lit digit and its segments on every clock. If the hour wrap were wrong, 12 would be followed by 13 or by 0 instead of 1. A wrong tens limit would show minutes such as 60 or roll over at 50. If the hours tens digit were not blanked, a dark slot would light as "0" for hours 1 through 9. If the display were gated wrongly, it would draw drive current while dark, or timekeeping would stop while the display is off. A wrong tap on the divider would give the wrong pace in normal or fast mode, and the minute change would then land on the wrong cycle.

// File: rtl/watch_pkg.sv
// Shared constants and the seven-segment code function for the watch core.
// Assumes active-high segments packed g..a in bits 6..0.
package watch_pkg;

    localparam int N_DIGITS      = 4;
    localparam int SEL_W         = $clog2(N_DIGITS);
    localparam logic [3:0] CODE_DARK = 4'hF;

    // Map one BCD code to its segment pattern; codes above 9 stay dark.
    function automatic logic [6:0] seg_of(input logic [3:0] code);
        logic [6:0] pat;
        case (code)
            4'd0:    pat = 7'h3F;
            4'd1:    pat = 7'h06;
            4'd2:    pat = 7'h5B;
            4'd3:    pat = 7'h4F;
            4'd4:    pat = 7'h66;
            4'd5:    pat = 7'h6D;
            4'd6:    pat = 7'h7D;
            4'd7:    pat = 7'h07;
            4'd8:    pat = 7'h7F;
            4'd9:    pat = 7'h6F;
            default: pat = 7'h00;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/watch_divider.sv
// Binary divider chain for the watch core.
// Produces a one-clock seconds pulse (full chain, or the shortened chain
// while fast_set is held) and a one-clock scan pulse from the low bits.
// Assumes 1 <= SCAN_BITS <= DIV_STAGES and FAST_SKIP < DIV_STAGES.
module watch_divider #(
    parameter int DIV_STAGES = 15,
    parameter int FAST_SKIP  = 8,
    parameter int SCAN_BITS  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_set,
    output logic sec_tick,
    output logic scan_tick
);
    localparam int FAST_BITS = DIV_STAGES - FAST_SKIP;

    logic [DIV_STAGES-1:0] div_q;

    // Free-running count; each bit is one divide-by-two stage.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Seconds pulse taps the whole chain, or skips the top stages in fast set.
    always_comb begin
        if (fast_set) sec_tick = &div_q[FAST_BITS-1:0];
        else          sec_tick = &div_q;
    end

    // Scan pulse taps the low stages.
    assign scan_tick = &div_q[SCAN_BITS-1:0];

    // Two seconds pulses never come on consecutive clocks in either mode.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // A normal-mode pulse marks the chain wrapping back to zero.
    p_norm_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !fast_set) |=> (div_q == '0));

    // A fast-mode pulse leaves the low stages at zero on the next clock.
    p_fast_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && fast_set) |=> (div_q[FAST_BITS-1:0] == '0));

endmodule

// File: rtl/watch_bcd_stage.sv
// One decimal counter stage, counting 0..MOD-1 on each enable.
// carry is high in the enabled clock that wraps the stage back to zero.
// Assumes 2 <= MOD <= 10.
module watch_bcd_stage #(
    parameter int MOD = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output logic [3:0] digit,
    output logic       carry
);
    localparam logic [3:0] LAST = 4'(MOD - 1);

    // Count on enable and wrap at the stage limit.
    always_ff @(posedge clk) begin
        if (!rst_n)          digit <= '0;
        else if (en) begin
            if (digit == LAST) digit <= '0;
            else               digit <= digit + 4'd1;
        end
    end

    // Carry out on the wrapping step.
    assign carry = en && (digit == LAST);

    // Stage never leaves its range.
    p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        digit <= LAST);

    // Enabled at the last value, the stage returns to zero.
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && digit == LAST) |=> (digit == 4'd0));

endmodule

// File: rtl/watch_hour_stage.sv
// Twelve-hour counter kept as a tens bit and a units digit.
// Sequence on each enable: 12, 1, 2, ..., 9, 10, 11, 12.
module watch_hour_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output logic [3:0] hr_units,
    output logic [3:0] hr_tens
);
    logic tens_q;

    // Step the hour, folding 12 back to 1 and 9 over to 10.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tens_q   <= 1'b1;
            hr_units <= 4'd2;
        end else if (en) begin
            if (tens_q && hr_units == 4'd2) begin
                tens_q   <= 1'b0;
                hr_units <= 4'd1;
            end else if (hr_units == 4'd9) begin
                tens_q   <= 1'b1;
                hr_units <= 4'd0;
            end else begin
                hr_units <= hr_units + 4'd1;
            end
        end
    end

    assign hr_tens = {3'b000, tens_q};

    // Hour stays inside 1..12.
    p_hour_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tens_q ? (hr_units <= 4'd2) : (hr_units >= 4'd1 && hr_units <= 4'd9));

    // Twelve is followed by one.
    p_hour_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tens_q && hr_units == 4'd2) |=> (!tens_q && hr_units == 4'd1));

endmodule

// File: rtl/watch_display.sv
// Digit scanner with one shared seven-segment decoder.
// A pointer walks the four slots on each scan pulse. The selected BCD value
// goes through the single decoder. Everything is dark unless show_req is high.
// A zero hours-tens digit is shown as a dark slot.
module watch_display
    import watch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_tick,
    input  logic                show_req,
    input  logic [3:0]          min_units,
    input  logic [3:0]          min_tens,
    input  logic [3:0]          hr_units,
    input  logic [3:0]          hr_tens,
    output logic [6:0]          seg_out,
    output logic [N_DIGITS-1:0] dig_en
);
    logic [SEL_W-1:0] dsel_q;
    logic [3:0]       pick;
    logic             dark_slot;
    logic [3:0]       code;

    // Advance the digit pointer on every scan pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         dsel_q <= '0;
        else if (scan_tick) dsel_q <= dsel_q + 1'b1;
    end

    // Steer the selected counter value toward the decoder.
    always_comb begin
        case (dsel_q)
            2'd0:    pick = min_units;
            2'd1:    pick = min_tens;
            2'd2:    pick = hr_units;
            default: pick = hr_tens;
        endcase
    end

    // Suppress a leading zero in the hours.
    assign dark_slot = (dsel_q == 2'd3) && (hr_tens == 4'd0);
    assign code      = dark_slot ? CODE_DARK : pick;

    // Shared decoder and drive gating for power.
    always_comb begin
        seg_out = show_req ? seg_of(code) : 7'h00;
        dig_en  = (show_req && !dark_slot) ? (N_DIGITS'(1) << dsel_q) : '0;
    end

    // No drive while the display is not requested.
    p_dark_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !show_req |-> (seg_out == 7'h00 && dig_en == '0));

    // Never more than one digit driven.
    p_one_digit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en));

    // Leading zero of the hours stays dark.
    p_lead_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_q == 2'd3 && hr_tens == 4'd0) |-> (seg_out == 7'h00 && dig_en == '0));

    // Pointer only moves on a scan pulse.
    p_scan_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(dsel_q));

endmodule

// File: rtl/watch_core.sv
// Watch timekeeping core: divider, seconds/minutes counters, twelve-hour
// counter and a scanned four-digit display with one decoder.
// Assumes clk is the crystal clock and rst_n is synchronous.
module watch_core
    import watch_pkg::*;
#(
    parameter int DIV_STAGES = 15,
    parameter int FAST_SKIP  = 8,
    parameter int SCAN_BITS  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fast_set,
    input  logic       show_req,
    output logic [6:0] seg_out,
    output logic [3:0] dig_en
);
    localparam int N_STAGES = 4;   // sec units, sec tens, min units, min tens

    logic                          sec_tick;
    logic                          scan_tick;
    logic [N_STAGES:0]             stage_en;
    logic [N_STAGES-1:0][3:0]      cnt_digit;
    logic [3:0]                    hr_units;
    logic [3:0]                    hr_tens;

    watch_divider #(
        .DIV_STAGES(DIV_STAGES),
        .FAST_SKIP (FAST_SKIP),
        .SCAN_BITS (SCAN_BITS)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_set (fast_set),
        .sec_tick (sec_tick),
        .scan_tick(scan_tick)
    );

    assign stage_en[0] = sec_tick;

    // Units stages wrap at ten, tens stages at six.
    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        watch_bcd_stage #(
            .MOD(((i % 2) == 0) ? 10 : 6)
        ) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (stage_en[i]),
            .digit(cnt_digit[i]),
            .carry(stage_en[i+1])
        );
    end

    watch_hour_stage u_hours (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (stage_en[N_STAGES]),
        .hr_units(hr_units),
        .hr_tens (hr_tens)
    );

    watch_display u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_tick(scan_tick),
        .show_req (show_req),
        .min_units(cnt_digit[2]),
        .min_tens (cnt_digit[3]),
        .hr_units (hr_units),
        .hr_tens  (hr_tens),
        .seg_out  (seg_out),
        .dig_en   (dig_en)
    );

    // Minutes only move while the seconds read 00.
    p_min_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_digit[2]) |-> (cnt_digit[0] == 4'd0 && cnt_digit[1] == 4'd0));

endmodule

// File: tb/watch_core_tb.sv
// Bench: small divider configuration, fast-set sweep over a full twelve-hour
// cycle, with every displayed slot compared against an arithmetic model.
module watch_core_tb;
    localparam int DS = 3;
    localparam int FS = 2;
    localparam int SB = 1;
    localparam int FB = DS - FS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_set = 1'b0;
    logic       show_req = 1'b0;
    logic [6:0] seg_out;
    logic [3:0] dig_en;

    int  checks = 0;
    int  errors = 0;
    int  m_div = 0;
    int  m_secs = 0;
    int  m_dsel = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    watch_core #(.DIV_STAGES(DS), .FAST_SKIP(FS), .SCAN_BITS(SB)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_set(fast_set),
        .show_req(show_req),
        .seg_out (seg_out),
        .dig_en  (dig_en)
    );

    // Segment patterns of R7, g..a in bits 6..0.
    function automatic logic [6:0] seg_ref(input int v);
        case (v)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    // Compare the outputs with the model, then step the model one clock.
    task automatic cycle(input string tag, input bit do_check);
        int hh, dh, mm, val;
        bit dark;
        logic [6:0] e_seg;
        logic [3:0] e_en;
        string sub;
        int fm, sm, full;
        bit tick, scan;
        #1;
        if (do_check) begin
            hh = m_secs / 3600;
            dh = (hh == 0) ? 12 : hh;
            mm = (m_secs / 60) % 60;
            case (m_dsel)
                0: val = mm % 10;
                1: val = mm / 10;
                2: val = dh % 10;
                default: val = dh / 10;
            endcase
            dark  = (m_dsel == 3) && (dh / 10 == 0);
            e_en  = (show_req && !dark) ? 4'(1 << m_dsel) : 4'b0000;
            e_seg = (show_req && !dark) ? seg_ref(val) : 7'h00;
            if (!show_req)        sub = "R8";
            else if (dark)        sub = "R9";
            else if (dig_en !== e_en) sub = "R6";
            else                  sub = "R7";
            checks++;
            if (seg_out !== e_seg || dig_en !== e_en) begin
                errors++;
                $display("FAIL %s/%s t=%0d seg=%h en=%b expected seg=%h en=%b",
                         tag, sub, m_secs, seg_out, dig_en, e_seg, e_en);
            end
            checks++;
            if ($countones(dig_en) > 1) begin
                errors++;
                $display("FAIL R10 en=%b expected at most one bit", dig_en);
            end
        end
        if (!rst_n) begin
            m_div = 0; m_secs = 0; m_dsel = 0;
        end else begin
            fm   = (1 << FB) - 1;
            sm   = (1 << SB) - 1;
            full = (1 << DS) - 1;
            tick = fast_set ? ((m_div & fm) == fm) : (m_div == full);
            scan = ((m_div & sm) == sm);
            m_div = (m_div + 1) % (1 << DS);
            if (tick) m_secs = (m_secs + 1) % 43200;
            if (scan) m_dsel = (m_dsel + 1) % 4;
        end
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        // Reset held for a few clocks.
        for (int i = 0; i < 3; i++) cycle("R1", 1'b0);
        rst_n = 1'b1; show_req = 1'b1;
        // R1: 12:00 shown straight after reset.
        for (int i = 0; i < 16; i++) cycle("R1", 1'b1);
        // R2: normal pace, covers the first minute change.
        for (int i = 0; i < 1000; i++) cycle("R2", 1'b1);
        // R8: display off, time keeps running.
        show_req = 1'b0;
        for (int i = 0; i < 200; i++) cycle("R8", 1'b1);
        // R5 with R3/R4: fast sweep over a full twelve-hour cycle.
        show_req = 1'b1; fast_set = 1'b1;
        for (int i = 0; i < 86500; i++) begin
            if ((m_secs % 3600) < 120)   cycle("R4", 1'b1);
            else if ((m_secs % 60) < 2)  cycle("R3", 1'b1);
            else                         cycle("R5", 1'b1);
        end
        // R2: back to normal pace.
        fast_set = 1'b0;
        for (int i = 0; i < 600; i++) cycle("R2", 1'b1);
        // R1: reset in the middle of a run.
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) cycle("R1", 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) cycle("R1", 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 195000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule